// File: doc/BRIEF.md
# Dual-Speed Single-Line Bus Slave Front End

This block sits between the single open-drain bus line of a one-wire slave device and the command layer behind it. It synchronizes the line into the system clock domain. It times every low period with one counter and sorts each low period into one of two kinds: a bus reset or a data time slot. A reset is any low period longer than the threshold for the active speed. A data time slot starts on a falling edge driven by the master. After a reset, the block answers with a presence pulse. It then assembles the bits written by the master into bytes, least significant bit first. The first byte after each reset is tagged as the ROM function command, and every later byte is handed over untagged.

The command layer can also send data. While `tx_en` is high and the command byte has been received, read slots drive the bits of `tx_byte` onto the line. A 0 is sent by holding the line low for a fixed time and a 1 by leaving the line released. All durations are parameters given in clock cycles, with one set for regular speed and one for overdrive. The command layer enters overdrive with `od_set`, and a reset long enough for regular speed leaves it. Bit and byte position are kept for as long as the line idles high, so a suspended transaction can resume.

Top module: `owire_front`

## Requirements
- R1: A low period of at least RST_STD cycles at regular speed is a bus reset and is followed by a presence pulse; a shorter low period is not a reset.
- R2: In overdrive, a low period of at least RST_OD cycles is a bus reset and is followed by a presence pulse.
- R3: A reset with a low period of at least RST_STD cycles clears `od_mode`, whatever the speed. An overdrive reset shorter than RST_STD leaves `od_mode` set.
- R4: The presence pulse drives `bus_pull` high for exactly PD_LEN_STD cycles (PD_LEN_OD in overdrive). It starts between PD_WAIT and PD_WAIT+4 cycles after the line is released.
- R5: In a write slot, the line is sampled SAMPLE cycles after the falling edge. Low at that point is a 0 and high is a 1. Bits fill a byte starting at bit 0.
- R6: When eight bits have been received, `byte_valid` pulses for one cycle with the byte on `byte_data`. `byte_is_cmd` is 1 only for the first byte after a reset.
- R7: In a read slot after the command byte, with `tx_en` high, a 0 bit of `tx_byte` (bit index = position in the byte) holds `bus_pull` high for exactly RD_HOLD cycles, and a 1 bit leaves it low. Slots of the command byte are never driven.
- R8: A line that idles high between slots keeps the bit position, so a byte split by a long pause is assembled as if it had been sent without one.
- R9: Before the first bus reset, slots produce no byte and no pull.
- R10: A pulse on `od_set` sets `od_mode`. `od_mode` rises only after `od_set`. Out of `rst_n`, `od_mode` is 0.
- R11: `bus_pull` is low out of `rst_n` and never stays high longer than the longest presence or read-hold time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_in | input | 1 | Level of the bus line (wired-AND of all drivers) |
| bus_pull | output | 1 | 1 = pull the line low through the open-drain driver |
| od_set | input | 1 | One-cycle request from the command layer to enter overdrive |
| od_mode | output | 1 | 1 = overdrive timing active |
| tx_en | input | 1 | 1 = slots after the command byte are read slots |
| tx_byte | input | 8 | Byte to send, bit 0 first |
| byte_valid | output | 1 | One-cycle strobe: a byte is complete |
| byte_data | output | 8 | Completed byte, first bit in bit 0 |
| byte_is_cmd | output | 1 | With byte_valid: the byte is the first after a reset |

## Verification
The bound checker watches, on every cycle, four things: the length of each pull run, the one-cycle shape of the byte strobe, that overdrive is entered only on request, and that overdrive is left only while the line has been low. Other behaviours need whole scenarios, so only the bench can show them. These are the reset thresholds at each speed, and the exact presence delay and width. They also include bit order within a byte, the command tag after a reset, the read-slot hold time per bit value, and resumption after a pause with the line high.

// File: rtl/owire_pkg.sv
package owire_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,   // line high, waiting for a falling edge
    ST_SLOT,   // inside a time slot
    ST_RST,    // low period qualified as a reset
    ST_PDW,    // waiting before the presence pulse
    ST_PDD,    // driving the presence pulse
    ST_PDR     // presence released, waiting for line high
  } ow_state_e;

  function automatic int ow_max(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/owire_sync.sv
module owire_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic line_s,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= 1'b1;
    else        chain[0] <= din;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[g] <= 1'b1;
      else        chain[g] <= chain[g-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= 1'b1;
    else        prev <= chain[STAGES-1];
  end

  assign line_s = chain[STAGES-1];
  assign fall   = prev & ~chain[STAGES-1];
endmodule

// File: rtl/owire_slot.sv
module owire_slot
  import owire_pkg::*;
#(
  parameter int RST_STD    = 12000,
  parameter int RST_OD     = 1600,
  parameter int SAMPLE_STD = 3000,
  parameter int SAMPLE_OD  = 250,
  parameter int RD_HOLD_STD = 3000,
  parameter int RD_HOLD_OD  = 250,
  parameter int PD_WAIT_STD = 3000,
  parameter int PD_WAIT_OD  = 300,
  parameter int PD_LEN_STD  = 12000,
  parameter int PD_LEN_OD   = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_s,
  input  logic fall,
  input  logic od,
  input  logic tx_drive,
  input  logic tx_bit,
  output logic pull,
  output logic bit_ev,
  output logic bit_val,
  output logic rst_ev,
  output logic od_clr
);
  localparam int CMAX = ow_max(ow_max(RST_STD, PD_LEN_STD), ow_max(PD_WAIT_STD, SAMPLE_STD));
  localparam int CW   = $clog2(CMAX + 2) + 1;
  localparam logic [CW-1:0] CTOP = '1;

  ow_state_e st, st_n;
  logic [CW-1:0] cnt, cnt_n;
  logic smp, smp_n;
  logic [CW-1:0] lim_rst, lim_smp, lim_hold, lim_pdw, lim_pdl;

  always_comb begin
    lim_rst  = od ? CW'(RST_OD)     : CW'(RST_STD);
    lim_smp  = od ? CW'(SAMPLE_OD)  : CW'(SAMPLE_STD);
    lim_hold = od ? CW'(RD_HOLD_OD) : CW'(RD_HOLD_STD);
    lim_pdw  = od ? CW'(PD_WAIT_OD) : CW'(PD_WAIT_STD);
    lim_pdl  = od ? CW'(PD_LEN_OD)  : CW'(PD_LEN_STD);
  end

  always_comb begin
    st_n    = st;
    cnt_n   = (cnt == CTOP) ? cnt : cnt + 1'b1;
    smp_n   = smp;
    pull    = 1'b0;
    bit_ev  = 1'b0;
    bit_val = smp;
    rst_ev  = 1'b0;
    od_clr  = 1'b0;
    unique case (st)
      ST_IDLE: begin
        cnt_n = '0;
        if (fall) st_n = ST_SLOT;
      end
      ST_SLOT: begin
        pull = tx_drive & ~tx_bit & (cnt < lim_hold);
        if (cnt == lim_smp - 1'b1) begin
          smp_n = line_s;
          if (line_s) begin
            bit_ev  = 1'b1;
            bit_val = 1'b1;
            st_n    = ST_IDLE;
          end
        end else if (cnt >= lim_smp && line_s) begin
          bit_ev = 1'b1;
          st_n   = ST_IDLE;
        end else if (!line_s && cnt >= lim_rst - 1'b1) begin
          rst_ev = 1'b1;
          st_n   = ST_RST;
        end
      end
      ST_RST: begin
        if (!line_s && cnt >= CW'(RST_STD - 1)) od_clr = 1'b1;
        if (line_s) begin
          st_n  = ST_PDW;
          cnt_n = '0;
        end
      end
      ST_PDW: begin
        if (!line_s) begin
          st_n  = ST_SLOT;
          cnt_n = '0;
        end else if (cnt >= lim_pdw - 1'b1) begin
          st_n  = ST_PDD;
          cnt_n = '0;
        end
      end
      ST_PDD: begin
        pull = 1'b1;
        if (cnt >= lim_pdl - 1'b1) begin
          st_n  = ST_PDR;
          cnt_n = '0;
        end
      end
      ST_PDR: begin
        if (line_s) begin
          st_n = ST_IDLE;
        end else if (cnt >= lim_rst - 1'b1) begin
          rst_ev = 1'b1;
          st_n   = ST_RST;
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= ST_IDLE;
      cnt <= '0;
      smp <= 1'b1;
    end else begin
      st  <= st_n;
      cnt <= cnt_n;
      smp <= smp_n;
    end
  end
endmodule

// File: rtl/owire_bytes.sv
module owire_bytes #(
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rst_ev,
  input  logic          bit_ev,
  input  logic          bit_val,
  input  logic          tx_en,
  input  logic [BW-1:0] tx_byte,
  output logic          tx_drive,
  output logic          tx_bit,
  output logic          byte_valid,
  output logic [BW-1:0] byte_data,
  output logic          byte_is_cmd
);
  localparam int IW = $clog2(BW);
  localparam logic [IW-1:0] ILAST = IW'(BW - 1);

  logic          active, active_n;
  logic          first, first_n;
  logic [IW-1:0] idx, idx_n;
  logic [BW-1:0] sh, sh_n;
  logic          vld_n, cmd_n;
  logic [BW-1:0] data_n;

  assign tx_drive = active & ~first & tx_en;
  assign tx_bit   = tx_byte[idx];

  always_comb begin
    active_n = active;
    first_n  = first;
    idx_n    = idx;
    sh_n     = sh;
    vld_n    = 1'b0;
    cmd_n    = 1'b0;
    data_n   = byte_data;
    if (rst_ev) begin
      active_n = 1'b1;
      first_n  = 1'b1;
      idx_n    = '0;
    end else if (bit_ev && active) begin
      sh_n  = {bit_val, sh[BW-1:1]};
      idx_n = idx + 1'b1;
      if (idx == ILAST) begin
        vld_n   = 1'b1;
        cmd_n   = first;
        data_n  = {bit_val, sh[BW-1:1]};
        first_n = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active      <= 1'b0;
      first       <= 1'b1;
      idx         <= '0;
      sh          <= '0;
      byte_valid  <= 1'b0;
      byte_is_cmd <= 1'b0;
      byte_data   <= '0;
    end else begin
      active      <= active_n;
      first       <= first_n;
      idx         <= idx_n;
      sh          <= sh_n;
      byte_valid  <= vld_n;
      byte_is_cmd <= cmd_n;
      byte_data   <= data_n;
    end
  end
endmodule

// File: rtl/owire_front.sv
module owire_front #(
  parameter int SYNC_STAGES = 2,
  parameter int RST_STD     = 12000,
  parameter int RST_OD      = 1600,
  parameter int SAMPLE_STD  = 3000,
  parameter int SAMPLE_OD   = 250,
  parameter int RD_HOLD_STD = 3000,
  parameter int RD_HOLD_OD  = 250,
  parameter int PD_WAIT_STD = 3000,
  parameter int PD_WAIT_OD  = 300,
  parameter int PD_LEN_STD  = 12000,
  parameter int PD_LEN_OD   = 1000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_in,
  output logic       bus_pull,
  input  logic       od_set,
  output logic       od_mode,
  input  logic       tx_en,
  input  logic [7:0] tx_byte,
  output logic       byte_valid,
  output logic [7:0] byte_data,
  output logic       byte_is_cmd
);
  logic line_s, fall;
  logic tx_drive, tx_bit;
  logic bit_ev, bit_val, rst_ev, od_clr;
  logic od_n;

  owire_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(bus_in), .line_s(line_s), .fall(fall)
  );

  owire_slot #(
    .RST_STD(RST_STD), .RST_OD(RST_OD),
    .SAMPLE_STD(SAMPLE_STD), .SAMPLE_OD(SAMPLE_OD),
    .RD_HOLD_STD(RD_HOLD_STD), .RD_HOLD_OD(RD_HOLD_OD),
    .PD_WAIT_STD(PD_WAIT_STD), .PD_WAIT_OD(PD_WAIT_OD),
    .PD_LEN_STD(PD_LEN_STD), .PD_LEN_OD(PD_LEN_OD)
  ) u_slot (
    .clk(clk), .rst_n(rst_n), .line_s(line_s), .fall(fall), .od(od_mode),
    .tx_drive(tx_drive), .tx_bit(tx_bit), .pull(bus_pull),
    .bit_ev(bit_ev), .bit_val(bit_val), .rst_ev(rst_ev), .od_clr(od_clr)
  );

  owire_bytes #(.BW(8)) u_bytes (
    .clk(clk), .rst_n(rst_n), .rst_ev(rst_ev), .bit_ev(bit_ev),
    .bit_val(bit_val), .tx_en(tx_en), .tx_byte(tx_byte),
    .tx_drive(tx_drive), .tx_bit(tx_bit), .byte_valid(byte_valid),
    .byte_data(byte_data), .byte_is_cmd(byte_is_cmd)
  );

  // clearing by a long reset wins over a simultaneous request
  always_comb begin
    od_n = od_mode;
    if (od_clr)      od_n = 1'b0;
    else if (od_set) od_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) od_mode <= 1'b0;
    else        od_mode <= od_n;
  end
endmodule

// File: rtl/owire_front_chk.sv
module owire_front_chk #(
  parameter int RUN_MAX = 12000
) (
  input logic clk,
  input logic rst_n,
  input logic bus_in,
  input logic bus_pull,
  input logic od_set,
  input logic od_mode,
  input logic byte_valid
);
  logic [31:0] run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        run <= '0;
    else if (bus_pull) run <= run + 1'b1;
    else               run <= '0;
  end

  // R11: no pull run longer than the longest presence or read hold
  a_r11_pull_run: assert property (@(posedge clk) disable iff (!rst_n)
    bus_pull |-> (run < 32'(RUN_MAX)));

  // R10: overdrive is entered only on request
  a_r10_od_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(od_mode) |-> $past(od_set));

  // R3: overdrive is left only while the line has been low
  a_r3_od_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(od_mode) |-> !$past(bus_in, 2));

  // R6: byte strobe lasts one cycle
  a_r6_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |=> !byte_valid);
endmodule

bind owire_front owire_front_chk #(
  .RUN_MAX((PD_LEN_STD > RD_HOLD_STD) ? PD_LEN_STD : RD_HOLD_STD)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_in(bus_in), .bus_pull(bus_pull),
  .od_set(od_set), .od_mode(od_mode), .byte_valid(byte_valid)
);

// File: tb/owire_front_tb.sv
module owire_front_tb_top;
  localparam int RST_STD = 120, RST_OD = 16;
  localparam int SMP_STD = 30, SMP_OD = 4;
  localparam int HLD_STD = 30, HLD_OD = 4;
  localparam int PDW_STD = 20, PDW_OD = 3;
  localparam int PDL_STD = 100, PDL_OD = 10;

  logic clk = 1'b0;
  logic rst_n;
  logic m_low;
  logic bus_in, bus_pull, od_set, od_mode, tx_en;
  logic [7:0] tx_byte, byte_data;
  logic byte_valid, byte_is_cmd;

  int checks = 0, errors = 0;
  int nbytes = 0, pull_total = 0;
  logic [7:0] last_byte;
  logic last_cmd;

  always #5 clk = ~clk;
  assign bus_in = ~(m_low | bus_pull);

  owire_front #(
    .RST_STD(RST_STD), .RST_OD(RST_OD), .SAMPLE_STD(SMP_STD), .SAMPLE_OD(SMP_OD),
    .RD_HOLD_STD(HLD_STD), .RD_HOLD_OD(HLD_OD), .PD_WAIT_STD(PDW_STD),
    .PD_WAIT_OD(PDW_OD), .PD_LEN_STD(PDL_STD), .PD_LEN_OD(PDL_OD)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_in(bus_in), .bus_pull(bus_pull),
    .od_set(od_set), .od_mode(od_mode), .tx_en(tx_en), .tx_byte(tx_byte),
    .byte_valid(byte_valid), .byte_data(byte_data), .byte_is_cmd(byte_is_cmd)
  );

  always @(negedge clk) begin
    if (bus_pull) pull_total++;
    if (byte_valid) begin
      nbytes++;
      last_byte = byte_data;
      last_cmd  = byte_is_cmd;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // master reset pulse; measure presence delay and width
  task automatic bus_reset(input int len, input logic od_exp, input string req);
    int d, w;
    m_low = 1'b1; tick(len); m_low = 1'b0;
    d = 0;
    while (!bus_pull && d < 400) begin tick(1); d++; end
    w = 0;
    while (bus_pull && w < 400) begin tick(1); w++; end
    checks++;
    if (d < (od_exp ? PDW_OD : PDW_STD) || d > (od_exp ? PDW_OD : PDW_STD) + 4) begin
      errors++;
      $display("FAIL %s/R4 presence delay: actual %0d expected %0d..+4", req, d,
               od_exp ? PDW_OD : PDW_STD);
    end
    check({req, "/R4 presence width"}, w, od_exp ? PDL_OD : PDL_STD);
    tick(6);
  endtask

  task automatic write_bit(input logic b, input logic od);
    int lo, tot;
    tot = od ? 14 : 70;
    lo  = od ? (b ? 1 : 8) : (b ? 5 : 45);
    m_low = 1'b1; tick(lo); m_low = 1'b0; tick(tot - lo);
  endtask

  task automatic write_byte(input logic [7:0] v, input logic od);
    for (int i = 0; i < 8; i++) write_bit(v[i], od);
  endtask

  task automatic read_bit(input logic exp_b, input logic od, input string req);
    int p0, seen;
    p0 = pull_total;
    m_low = 1'b1; tick(od ? 3 : 4); m_low = 1'b0;
    tick(od ? 1 : 11);
    seen = bus_in;
    tick(od ? 10 : 55);
    check({req, " line level"}, seen, exp_b);
    check({req, " hold cycles"}, pull_total - p0, exp_b ? 0 : (od ? HLD_OD : HLD_STD));
  endtask

  // {od, cmd byte, data byte}
  localparam logic [16:0] VEC [4] = '{
    {1'b0, 8'hCC, 8'h5A},
    {1'b1, 8'h3C, 8'h81},
    {1'b0, 8'h0F, 8'hFE},
    {1'b1, 8'hF0, 8'h01}
  };

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int nb, pt;
    rst_n = 1'b0; m_low = 1'b0; od_set = 1'b0; tx_en = 1'b0; tx_byte = 8'h00;
    tick(5); rst_n = 1'b1; tick(3);
    check("R11 reset pull", bus_pull, 0);
    check("R10 reset od", od_mode, 0);
    check("R6 reset valid", byte_valid, 0);

    // R9: no reset seen yet
    write_byte(8'hA5, 1'b0);
    check("R9 no byte before reset", nbytes, 0);
    check("R9 no pull before reset", pull_total, 0);

    // R1: short low is not a reset
    pt = pull_total;
    m_low = 1'b1; tick(100); m_low = 1'b0; tick(200);
    check("R1 short low no presence", pull_total - pt, 0);

    // table walk
    for (int k = 0; k < 4; k++) begin
      logic vod;
      vod = VEC[k][16];
      bus_reset(130, 1'b0, "R1");
      check("R3 regular reset clears od", od_mode, 0);
      if (vod) begin
        od_set = 1'b1; tick(1); od_set = 1'b0; tick(2);
        check("R10 od set", od_mode, 1);
        bus_reset(20, 1'b1, "R2");
        check("R3 od reset keeps od", od_mode, 1);
      end
      nb = nbytes;
      write_byte(VEC[k][15:8], vod);
      check("R6 cmd count", nbytes - nb, 1);
      check("R5 cmd value", last_byte, VEC[k][15:8]);
      check("R6 cmd tag", last_cmd, 1);
      write_byte(VEC[k][7:0], vod);
      check("R5 data value", last_byte, VEC[k][7:0]);
      check("R6 data tag", last_cmd, 0);
    end

    // R8: pause with line high in the middle of a byte
    bus_reset(130, 1'b0, "R8");
    write_byte(8'h99, 1'b0);
    for (int i = 0; i < 3; i++) write_bit(1'(8'h5A >> i), 1'b0);
    tick(600);
    for (int i = 3; i < 8; i++) write_bit(1'(8'h5A >> i), 1'b0);
    check("R8 resumed byte", last_byte, 8'h5A);
    check("R8 resumed tag", last_cmd, 0);

    // R7: read slots at regular speed, command byte never driven
    bus_reset(130, 1'b0, "R7");
    tx_en = 1'b1; tx_byte = 8'h6C;
    pt = pull_total;
    write_byte(8'hFF, 1'b0);
    check("R7 cmd slots not driven", pull_total - pt, 0);
    for (int i = 0; i < 8; i++) read_bit(tx_byte[i], 1'b0, "R7 regular read");
    check("R7 read byte echoed", last_byte, 8'h6C);
    tx_en = 1'b0;

    // R7 in overdrive
    od_set = 1'b1; tick(1); od_set = 1'b0;
    bus_reset(20, 1'b1, "R2");
    write_byte(8'h55, 1'b1);
    tx_en = 1'b1; tx_byte = 8'h81;
    for (int i = 0; i < 8; i++) read_bit(tx_byte[i], 1'b1, "R7 od read");
    tx_en = 1'b0;

    // R3: long reset while in overdrive leaves overdrive, regular presence
    check("R3 od before long reset", od_mode, 1);
    bus_reset(130, 1'b0, "R3");
    check("R3 long reset clears od", od_mode, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule